// File: doc/BRIEF.md
# Interrupt, Halt and Reset Sequencing Controller

This block sits beside a processor core's instruction sequencer and decides, at every instruction boundary, what kind of machine cycle the core runs next: an ordinary opcode fetch, a maskable interrupt acknowledge, a non-maskable restart, or an idle no-operation cycle while the core is halted. It latches falling edges of the asynchronous non-maskable request pin, so a brief pulse is never lost. It tracks the halt state and keeps the return address that points past the halt instruction.

It also owns reset. The reset pin must stay asserted for a set number of clocks before it takes effect. While reset is in effect the core's bus drivers are told to float. After release the core stays disabled for a fixed number of internal states, then starts with a forced jump to address zero. The core supplies the boundary strobe, the halt-decoded strobe, the interrupt-enable flag and the address of the next instruction. It reads back the cycle kind, a one-cycle program-counter load, the saved return address, an enable-clear pulse, the halt output and a core enable.

Top module: `ihr_ctrl`

## Requirements
- R1: A reset request held for fewer than RESET_HOLD (3) consecutive clocks has no effect. When it is held for RESET_HOLD clocks, `bus_float` is 1 and `core_en` is 0 after the RESET_HOLD-th rising edge.
- R2: While reset is in effect, `bus_float`=1, `core_en`=0, `halt_o`=0 and `ie_clr`=0, and boundary strobes change nothing (`cycle_req` stays 0).
- R3: After `reset_in` falls, `core_en` stays 0 for exactly WAKE_T (3) clocks. It rises together with a one-clock `force_en`=1, `force_pc`=0x0000 and `cycle_req`=0 (fetch).
- R4: Every decision is registered at a rising edge where `last_t`=1 and `core_en`=1 and is visible after that edge. With no pending request the decision is `cycle_req`=0 (fetch) and `force_en`=0.
- R5: A maskable request (`int_req`=1) at a boundary with `ie_flag`=1 gives `cycle_req`=1 (acknowledge), `ie_clr`=1 for one clock and `ret_addr`=`pc_next`. With `ie_flag`=0 it is ignored and gives a fetch.
- R6: `int_req` is sampled only at boundaries. With `last_t`=0, `cycle_req`, `force_en` and `ie_clr` do not change.
- R7: A falling edge on `nmi_n` is latched even when the pin returns high before the next boundary. The next boundary at least SYNC_STAGES+1 clocks later then gives `cycle_req`=2 (restart), `force_en`=1, `force_pc`=0x0066 and `ie_clr`=1, regardless of `ie_flag`.
- R8: A latched non-maskable request wins over a simultaneous enabled maskable request.
- R9: Taking the non-maskable request consumes the latch. The following boundary with no new edge gives a fetch.
- R10: A boundary with `halt_dec`=1 sets `halt_o`=1 and `cycle_req`=3 (no-operation). Further boundaries keep `halt_o`=1 and `cycle_req`=3 until an interrupt is accepted. A masked `int_req` does not end the halt.
- R11: Accepting a maskable interrupt while halted clears `halt_o` in the same decision. `ret_addr` then holds the `pc_next` value captured at the halt boundary.
- R12: A non-maskable request also ends the halt: `halt_o`=0, `cycle_req`=2, and `ret_addr` holds the address captured at the halt boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| reset_in | input | 1 | Reset request, active high, must be held RESET_HOLD clocks |
| nmi_n | input | 1 | Asynchronous non-maskable request, falling-edge active |
| int_req | input | 1 | Maskable interrupt request level |
| last_t | input | 1 | Strobe marking the last T-state of an instruction |
| halt_dec | input | 1 | The finishing instruction is a halt |
| ie_flag | input | 1 | Maskable interrupt enable from the core |
| pc_next | input | ADDR_W | Address of the instruction after the finishing one |
| cycle_req | output | 2 | Next cycle kind: 0 fetch, 1 acknowledge, 2 restart, 3 no-operation |
| force_en | output | 1 | One-clock program-counter load strobe |
| force_pc | output | ADDR_W | Value to load into the program counter |
| ret_addr | output | ADDR_W | Return address to save on an accepted interrupt |
| ie_clr | output | 1 | One-clock pulse telling the core to clear its enable flag |
| halt_o | output | 1 | Halt state indication, active high |
| core_en | output | 1 | Core may run |
| bus_float | output | 1 | Bus drivers must float (reset in effect) |

## Verification
A wrong reset-hold or wake counter shows up as `bus_float` or `core_en` changing one or more clocks early or late, at the edge where the count should end. A dropped or stuck non-maskable latch appears at the very next boundary, as a fetch where a restart was due or as a second restart. A halt flag that clears or sticks wrongly appears at the following boundary as the wrong `cycle_req` and `halt_o`. A stale halt return register shows up as a wrong `ret_addr` on the decision that leaves the halt.

// File: rtl/ihr_pkg.sv
package ihr_pkg;
  localparam int ADDR_W      = 16;
  localparam int RESET_HOLD  = 3;
  localparam int WAKE_T      = 3;
  localparam int SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] NMI_VEC = 16'h0066;
  localparam logic [ADDR_W-1:0] RST_VEC = 16'h0000;

  typedef enum logic [1:0] {
    CYC_FETCH   = 2'd0,
    CYC_IACK    = 2'd1,
    CYC_RESTART = 2'd2,
    CYC_NOP     = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/ihr_reset_seq.sv
module ihr_reset_seq
  import ihr_pkg::*;
#(
  parameter int HOLD = RESET_HOLD,
  parameter int WAKE = WAKE_T
) (
  input  logic clk,
  input  logic reset_in,
  output logic in_reset,
  output logic run,
  output logic go
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int WW = (WAKE > 1) ? $clog2(WAKE) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE - 1);

  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wake_cnt;
  phase_e        phase;

  // hold counter: saturates one below the accept count
  always_ff @(posedge clk) begin
    if (!reset_in)
      hold_cnt <= '0;
    else if (hold_cnt != HOLD_LAST)
      hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (reset_in && hold_cnt == HOLD_LAST) begin
      phase    <= PH_RESET;
      wake_cnt <= '0;
    end else begin
      case (phase)
        PH_RESET: if (!reset_in) begin
          phase    <= PH_WAKE;
          wake_cnt <= '0;
        end
        PH_WAKE: begin
          if (wake_cnt == WAKE_LAST) phase <= PH_RUN;
          else                       wake_cnt <= wake_cnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign in_reset = (phase == PH_RESET);
  assign run      = (phase == PH_RUN);
  assign go       = (phase == PH_WAKE) && (wake_cnt == WAKE_LAST) &&
                    !(reset_in && hold_cnt == HOLD_LAST);
endmodule

// File: rtl/ihr_nmi_latch.sv
module ihr_nmi_latch
  import ihr_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic nmi_n,
  input  logic clr,
  output logic pending
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              fell;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q <= nmi_n;
    end else begin : g_chain
      always_ff @(posedge clk) sync_q <= {sync_q[STAGES-2:0], nmi_n};
    end
  endgenerate

  always_ff @(posedge clk) last_q <= sync_q[STAGES-1];

  assign fell = last_q && !sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (clr)       pending <= 1'b0;
    else if (fell) pending <= 1'b1;
  end
endmodule

// File: rtl/ihr_arbiter.sv
module ihr_arbiter
  import ihr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          run,
  input  logic          go,
  input  logic          last_t,
  input  logic          int_req,
  input  logic          ie_flag,
  input  logic          halt_dec,
  input  logic          nmi_pend,
  input  logic [AW-1:0] pc_next,
  output logic          nmi_take,
  output cyc_kind_e     kind,
  output logic          force_en,
  output logic [AW-1:0] force_pc,
  output logic [AW-1:0] ret_addr,
  output logic          ie_clr,
  output logic          halt_q
);
  logic [AW-1:0] halt_ret;
  logic          boundary;
  logic          int_take;
  logic [AW-1:0] resume_pc;

  assign boundary  = run && last_t;
  assign nmi_take  = boundary && nmi_pend;
  assign int_take  = boundary && !nmi_pend && int_req && ie_flag;
  assign resume_pc = halt_q ? halt_ret : pc_next;

  always_ff @(posedge clk) begin
    force_en <= 1'b0;
    ie_clr   <= 1'b0;
    if (go) begin
      kind     <= CYC_FETCH;
      force_en <= 1'b1;
      force_pc <= RST_VEC;
      halt_q   <= 1'b0;
      ret_addr <= RST_VEC;
      halt_ret <= RST_VEC;
    end else if (!run) begin
      kind     <= CYC_FETCH;
      halt_q   <= 1'b0;
      force_pc <= RST_VEC;
      ret_addr <= RST_VEC;
      halt_ret <= RST_VEC;
    end else if (boundary) begin
      if (nmi_take) begin
        kind     <= CYC_RESTART;
        force_en <= 1'b1;
        force_pc <= NMI_VEC;
        ie_clr   <= 1'b1;
        halt_q   <= 1'b0;
        ret_addr <= resume_pc;
      end else if (int_take) begin
        kind     <= CYC_IACK;
        ie_clr   <= 1'b1;
        halt_q   <= 1'b0;
        ret_addr <= resume_pc;
      end else if (halt_q) begin
        kind     <= CYC_NOP;
      end else if (halt_dec) begin
        kind     <= CYC_NOP;
        halt_q   <= 1'b1;
        halt_ret <= pc_next;
      end else begin
        kind     <= CYC_FETCH;
      end
    end
  end
endmodule

// File: rtl/ihr_ctrl.sv
module ihr_ctrl
  import ihr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          reset_in,
  input  logic          nmi_n,
  input  logic          int_req,
  input  logic          last_t,
  input  logic          halt_dec,
  input  logic          ie_flag,
  input  logic [AW-1:0] pc_next,
  output logic [1:0]    cycle_req,
  output logic          force_en,
  output logic [AW-1:0] force_pc,
  output logic [AW-1:0] ret_addr,
  output logic          ie_clr,
  output logic          halt_o,
  output logic          core_en,
  output logic          bus_float
);
  logic      in_reset, run, go, nmi_pend, nmi_take;
  cyc_kind_e kind;

  ihr_reset_seq #(.HOLD(RESET_HOLD), .WAKE(WAKE_T)) u_seq (
    .clk(clk), .reset_in(reset_in), .in_reset(in_reset), .run(run), .go(go)
  );

  ihr_nmi_latch #(.STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .nmi_n(nmi_n), .clr(nmi_take || in_reset), .pending(nmi_pend)
  );

  ihr_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .run(run), .go(go), .last_t(last_t), .int_req(int_req),
    .ie_flag(ie_flag), .halt_dec(halt_dec), .nmi_pend(nmi_pend),
    .pc_next(pc_next), .nmi_take(nmi_take), .kind(kind),
    .force_en(force_en), .force_pc(force_pc), .ret_addr(ret_addr),
    .ie_clr(ie_clr), .halt_q(halt_o)
  );

  assign cycle_req = kind;
  assign core_en   = run;
  assign bus_float = in_reset;
endmodule

// File: rtl/ihr_ctrl_chk.sv
module ihr_ctrl_chk
  import ihr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          reset_in,
  input logic          nmi_n,
  input logic          int_req,
  input logic          last_t,
  input logic          halt_dec,
  input logic          ie_flag,
  input logic [AW-1:0] pc_next,
  input logic [1:0]    cycle_req,
  input logic          force_en,
  input logic [AW-1:0] force_pc,
  input logic [AW-1:0] ret_addr,
  input logic          ie_clr,
  input logic          halt_o,
  input logic          core_en,
  input logic          bus_float
);
  always @(negedge clk) begin
    if (bus_float)
      AST_FLOAT_QUIET: assert (!core_en && !halt_o && !force_en && !ie_clr); // R2
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (reset_in)
    $rose(core_en) |-> (force_en && force_pc == RST_VEC && cycle_req == 2'd0)); // R3

  AST_NO_DECIDE_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (reset_in)
    (core_en && !last_t) |=> ($stable(cycle_req) && !force_en && !ie_clr)); // R6

  AST_RESTART_VECTOR: assert property (@(posedge clk) disable iff (reset_in)
    (force_en && core_en && $past(core_en)) |-> (force_pc == NMI_VEC && cycle_req == 2'd2)); // R7

  AST_HALT_IDLES: assert property (@(posedge clk) disable iff (reset_in)
    halt_o |-> cycle_req == 2'd3); // R10

  AST_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (reset_in)
    ie_clr |-> (cycle_req == 2'd1 || cycle_req == 2'd2) && !halt_o); // R5
endmodule

bind ihr_ctrl ihr_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_ihr_ctrl.sv
module tb_ihr_ctrl;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          reset_in = 1'b1, nmi_n = 1'b1, int_req = 1'b0;
  logic          last_t = 1'b0, halt_dec = 1'b0, ie_flag = 1'b0;
  logic [AW-1:0] pc_next = '0;
  logic [1:0]    cycle_req;
  logic          force_en, ie_clr, halt_o, core_en, bus_float;
  logic [AW-1:0] force_pc, ret_addr;
  int            errors = 0, checks = 0;

  always #4 clk = ~clk;

  ihr_ctrl dut (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic boundary(input logic i, input logic ie, input logic h, input logic [AW-1:0] pc);
    int_req = i; ie_flag = ie; halt_dec = h; pc_next = pc; last_t = 1'b1;
    tick();
    last_t = 1'b0; int_req = 1'b0; halt_dec = 1'b0;
  endtask

  task automatic full_reset();
    reset_in = 1'b1;
    repeat (4) tick();
    check("R2", "bus_float", bus_float, 1);
    check("R2", "core_en", core_en, 0);
    boundary(1'b1, 1'b1, 1'b1, 16'h4000);
    check("R2", "cycle_req", cycle_req, 0);
    check("R2", "halt_o", halt_o, 0);
    check("R2", "ie_clr", ie_clr, 0);
    reset_in = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R3", "core_en during wake", core_en, 0);
      check("R3", "bus_float during wake", bus_float, 0);
    end
    tick();
    check("R3", "core_en", core_en, 1);
    check("R3", "force_en", force_en, 1);
    check("R3", "force_pc", force_pc, 0);
    check("R3", "cycle_req", cycle_req, 0);
    tick();
    check("R3", "force_en pulse", force_en, 0);
  endtask

  task automatic t_short_reset();
    reset_in = 1'b1;
    repeat (2) tick();
    check("R1", "core_en after 2", core_en, 1);
    check("R1", "bus_float after 2", bus_float, 0);
    reset_in = 1'b0;
    tick();
    check("R1", "core_en after release", core_en, 1);
    reset_in = 1'b1;
    repeat (2) tick();
    check("R1", "bus_float at 2", bus_float, 0);
    tick();
    check("R1", "bus_float at 3", bus_float, 1);
    check("R1", "core_en at 3", core_en, 0);
    full_reset();
  endtask

  task automatic t_plain_and_int();
    boundary(1'b0, 1'b1, 1'b0, 16'h0101);
    check("R4", "cycle_req idle", cycle_req, 0);
    check("R4", "force_en idle", force_en, 0);
    boundary(1'b1, 1'b0, 1'b0, 16'h0102);
    check("R5", "masked int", cycle_req, 0);
    check("R5", "masked ie_clr", ie_clr, 0);
    boundary(1'b1, 1'b1, 1'b0, 16'h0203);
    check("R5", "cycle_req iack", cycle_req, 1);
    check("R5", "ie_clr", ie_clr, 1);
    check("R5", "ret_addr", ret_addr, 16'h0203);
    tick();
    check("R5", "ie_clr pulse", ie_clr, 0);
    boundary(1'b0, 1'b1, 1'b0, 16'h0204);
    check("R4", "back to fetch", cycle_req, 0);
    int_req = 1'b1; ie_flag = 1'b1;
    repeat (3) tick();
    check("R6", "no boundary req", cycle_req, 0);
    check("R6", "no boundary ie_clr", ie_clr, 0);
    int_req = 1'b0;
  endtask

  task automatic t_nmi();
    nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    repeat (3) tick();
    check("R7", "no decision yet", cycle_req, 0);
    boundary(1'b1, 1'b1, 1'b0, 16'h0777);
    check("R8", "nmi over int", cycle_req, 2);
    check("R7", "force_en", force_en, 1);
    check("R7", "force_pc", force_pc, 16'h0066);
    check("R7", "ie_clr", ie_clr, 1);
    check("R7", "ret_addr", ret_addr, 16'h0777);
    boundary(1'b0, 1'b0, 1'b0, 16'h0067);
    check("R9", "latch consumed", cycle_req, 0);
    check("R9", "no force", force_en, 0);
    nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    repeat (3) tick();
    boundary(1'b0, 1'b0, 1'b0, 16'h0068);
    check("R7", "masked flag ignored", cycle_req, 2);
  endtask

  task automatic t_halt();
    boundary(1'b0, 1'b0, 1'b1, 16'h1235);
    check("R10", "halt_o", halt_o, 1);
    check("R10", "cycle_req nop", cycle_req, 3);
    boundary(1'b1, 1'b0, 1'b0, 16'h1235);
    check("R10", "masked int stays halted", halt_o, 1);
    check("R10", "still nop", cycle_req, 3);
    boundary(1'b1, 1'b1, 1'b0, 16'h9999);
    check("R11", "halt cleared", halt_o, 0);
    check("R11", "iack", cycle_req, 1);
    check("R11", "ret past halt", ret_addr, 16'h1235);
    boundary(1'b0, 1'b0, 1'b1, 16'h2001);
    check("R10", "halt again", halt_o, 1);
    nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    repeat (3) tick();
    check("R10", "halt held between boundaries", halt_o, 1);
    boundary(1'b0, 1'b0, 1'b0, 16'h5555);
    check("R12", "halt cleared by nmi", halt_o, 0);
    check("R12", "restart", cycle_req, 2);
    check("R12", "ret past halt", ret_addr, 16'h2001);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    full_reset();
    t_short_reset();
    t_plain_and_int();
    t_nmi();
    t_halt();
    summary();
    $finish;
  end
endmodule